// File: doc/BRIEF.md
# Scatter-Gather Buffer Address Generator

This block turns one transfer descriptor's buffer description into a stream of memory addresses while a transfer engine moves data. Software loads a short list of page frame numbers, a starting byte offset within the first page, and the total number of bytes to move. The engine then asks for bursts. For each burst the block answers with the address where the burst starts and the number of bytes granted. It then moves its offset forward, and its page index when a page ends, so that the next burst continues where the last one stopped.

An address is the current page frame number placed directly above the current page offset, so no adder sits in the address path. A burst is never allowed to run past the end of a 4 KB page. The grant is trimmed to whatever is left in the page, or to whatever is left of the transfer, whichever is smaller. The page list is short and fixed. If the transfer runs off the end of the last page while bytes are still owed, the block raises an error that holds until the next load.

Top module: `sg_addr_gen`

## Requirements
- R1: One cycle after `ld_strobe` is sampled high, `remaining` equals `ld_count`, the low 12 bits of `cur_addr` equal `ld_offset`, the page index is 0, `buf_err` is low, and `done` is high exactly when `ld_count` is 0.
- R2: `cur_addr` is the frame number of the current page in bits 31:12 and the page offset in bits 11:0. Frame k is bits 20k+19 to 20k of `ld_frames`, where k runs from 0 to 4.
- R3: An accepted request gets `ack_valid` high for one cycle, on the cycle after the request. `ack_addr` is the `cur_addr` value seen at the request. `ack_len` is the smallest of `req_len`, 4096 minus the offset, and `remaining`.
- R4: The offset advances by each granted length. When it reaches 4096 it wraps to 0, and the page index steps to the next frame unless it is already on the last one.
- R5: `remaining` drops by each granted length, and `done` is high whenever `remaining` is 0.
- R6: A request is ignored when `req_len` is 0, when `done` is high, or when `buf_err` is high. An ignored request gives no `ack_valid` and leaves `cur_addr` and `remaining` unchanged.
- R7: If a granted burst ends the last page while `remaining` is still nonzero, that burst is still acknowledged. `buf_err` then goes high and stays high until the next load, and no further requests are acknowledged.
- R8: A 16384-byte transfer starting at any offset, and a 20480-byte transfer starting at offset 0, both finish with `done` high and `buf_err` low.
- R9: When `ld_strobe` and `req_valid` are high in the same cycle, the load takes effect and the request is dropped without an acknowledge.
- R10: After reset, `remaining` is 0, `done` is high, `buf_err` and `ack_valid` are low, and `cur_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_strobe | input | 1 | Load the descriptor fields below |
| ld_frames | input | 100 | Five page frame numbers, frame 0 in the low bits |
| ld_offset | input | 12 | Starting byte offset in the first page |
| ld_count | input | 15 | Total bytes to transfer |
| req_valid | input | 1 | Burst request |
| req_len | input | 13 | Bytes asked for in the burst |
| ack_valid | output | 1 | Burst granted |
| ack_len | output | 13 | Bytes granted |
| ack_addr | output | 32 | Start address of the granted burst |
| cur_addr | output | 32 | Address of the next byte |
| remaining | output | 15 | Bytes still to transfer |
| done | output | 1 | No bytes remain |
| buf_err | output | 1 | The transfer ran past the last page (sticky) |

## Verification
The bench builds the block with its default parameters: 12-bit offsets, 20-bit frame numbers, five pages, a 15-bit byte count, and a 13-bit request length. With a 13-bit request, one burst can ask for more than a whole page, so the page-room clamp is tested on every page crossing. With a 15-bit count, a transfer can be loaded that is longer than five pages can hold, which is how the overrun error is reached. The same widths allow the full 20 KB run from offset 0 and 16 KB runs from the worst offsets 0xFFF and 0x7FF.

// File: rtl/sg_pkg.sv
package sg_pkg;

    // What the state machine does with the current cycle's inputs.
    typedef enum logic [1:0] {
        SG_OP_IDLE  = 2'd0,
        SG_OP_LOAD  = 2'd1,
        SG_OP_GRANT = 2'd2
    } sg_op_e;

endpackage

// File: rtl/sg_page_table.sv
module sg_page_table #(
    parameter int FRAME_BITS = 20,
    parameter int NUM_PAGES  = 5,
    parameter int IDX_BITS   = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [NUM_PAGES*FRAME_BITS-1:0] wr_frames,
    input  logic [IDX_BITS-1:0]             rd_idx,
    output logic [FRAME_BITS-1:0]           rd_frame
);

    logic [FRAME_BITS-1:0] frame_w [NUM_PAGES];

    // One register per list entry.
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
        logic [FRAME_BITS-1:0] entry_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (wr_en) begin
                entry_q <= wr_frames[g*FRAME_BITS +: FRAME_BITS];
            end
        end

        assign frame_w[g] = entry_q;
    end

    always_comb begin
        rd_frame = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (rd_idx == IDX_BITS'(i)) begin
                rd_frame = frame_w[i];
            end
        end
    end

endmodule

// File: rtl/sg_grant_calc.sv
module sg_grant_calc #(
    parameter int PAGE_BITS  = 12,
    parameter int COUNT_BITS = 15,
    parameter int REQ_BITS   = 13
) (
    input  logic [PAGE_BITS-1:0]  offset,
    input  logic [REQ_BITS-1:0]   req_len,
    input  logic [COUNT_BITS-1:0] remain,
    output logic [REQ_BITS-1:0]   grant,
    output logic                  ends_page
);

    localparam int WIDE_A = (REQ_BITS > COUNT_BITS) ? REQ_BITS : COUNT_BITS;
    localparam int CW     = (WIDE_A > PAGE_BITS + 1) ? WIDE_A : PAGE_BITS + 1;

    logic [CW-1:0] room;

    always_comb begin
        room  = (CW'(1) << PAGE_BITS) - CW'(offset);
        grant = req_len;
        if (CW'(req_len) > room) begin
            grant = REQ_BITS'(room);
        end
        if (CW'(grant) > CW'(remain)) begin
            grant = REQ_BITS'(remain);
        end
        ends_page = (CW'(grant) == room);
    end

endmodule

// File: rtl/sg_addr_gen.sv
module sg_addr_gen
    import sg_pkg::*;
#(
    parameter int PAGE_BITS  = 12,
    parameter int FRAME_BITS = 20,
    parameter int NUM_PAGES  = 5,
    parameter int COUNT_BITS = 15,
    parameter int REQ_BITS   = 13,
    localparam int ADDR_BITS = FRAME_BITS + PAGE_BITS,
    localparam int IDX_BITS  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ld_strobe,
    input  logic [NUM_PAGES*FRAME_BITS-1:0] ld_frames,
    input  logic [PAGE_BITS-1:0]            ld_offset,
    input  logic [COUNT_BITS-1:0]           ld_count,
    input  logic                            req_valid,
    input  logic [REQ_BITS-1:0]             req_len,
    output logic                            ack_valid,
    output logic [REQ_BITS-1:0]             ack_len,
    output logic [ADDR_BITS-1:0]            ack_addr,
    output logic [ADDR_BITS-1:0]            cur_addr,
    output logic [COUNT_BITS-1:0]           remaining,
    output logic                            done,
    output logic                            buf_err
);

    localparam logic [IDX_BITS-1:0] LAST_IDX = IDX_BITS'(NUM_PAGES - 1);

    typedef struct packed {
        logic [PAGE_BITS-1:0]  offset;
        logic [IDX_BITS-1:0]   idx;
        logic [COUNT_BITS-1:0] remain;
        logic                  err;
        logic                  ack;
        logic [REQ_BITS-1:0]   ack_len;
        logic [ADDR_BITS-1:0]  ack_addr;
    } sg_state_t;

    sg_state_t             s_d, s_q;
    sg_op_e                op;
    logic [FRAME_BITS-1:0] frame_sel;
    logic [REQ_BITS-1:0]   grant;
    logic                  ends_page;
    logic [COUNT_BITS-1:0] remain_after;

    sg_page_table #(
        .FRAME_BITS(FRAME_BITS),
        .NUM_PAGES (NUM_PAGES),
        .IDX_BITS  (IDX_BITS)
    ) u_pages (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_strobe),
        .wr_frames(ld_frames),
        .rd_idx   (s_q.idx),
        .rd_frame (frame_sel)
    );

    sg_grant_calc #(
        .PAGE_BITS (PAGE_BITS),
        .COUNT_BITS(COUNT_BITS),
        .REQ_BITS  (REQ_BITS)
    ) u_grant (
        .offset   (s_q.offset),
        .req_len  (req_len),
        .remain   (s_q.remain),
        .grant    (grant),
        .ends_page(ends_page)
    );

    // The address is the frame placed above the offset; no adder.
    assign cur_addr = {frame_sel, s_q.offset};

    always_comb begin
        if (ld_strobe) begin
            op = SG_OP_LOAD;
        end else if (req_valid && (req_len != '0) && (s_q.remain != '0) && !s_q.err) begin
            op = SG_OP_GRANT;
        end else begin
            op = SG_OP_IDLE;
        end
    end

    always_comb begin
        s_d          = s_q;
        s_d.ack      = 1'b0;
        remain_after = s_q.remain - COUNT_BITS'(grant);
        unique case (op)
            SG_OP_LOAD: begin
                s_d.offset = ld_offset;
                s_d.idx    = '0;
                s_d.remain = ld_count;
                s_d.err    = 1'b0;
            end
            SG_OP_GRANT: begin
                s_d.ack      = 1'b1;
                s_d.ack_len  = grant;
                s_d.ack_addr = cur_addr;
                s_d.remain   = remain_after;
                // A full-page grant truncates to 0, which still wraps correctly.
                s_d.offset   = s_q.offset + PAGE_BITS'(grant);
                if (ends_page) begin
                    if (s_q.idx == LAST_IDX) begin
                        if (remain_after != '0) begin
                            s_d.err = 1'b1;
                        end
                    end else begin
                        s_d.idx = s_q.idx + IDX_BITS'(1);
                    end
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_valid = s_q.ack;
    assign ack_len   = s_q.ack_len;
    assign ack_addr  = s_q.ack_addr;
    assign remaining = s_q.remain;
    assign done      = (s_q.remain == '0);
    assign buf_err   = s_q.err;

endmodule

// File: rtl/sg_addr_gen_chk.sv
module sg_addr_gen_chk #(
    parameter int PAGE_BITS  = 12,
    parameter int FRAME_BITS = 20,
    parameter int COUNT_BITS = 15,
    parameter int REQ_BITS   = 13,
    localparam int ADDR_BITS = FRAME_BITS + PAGE_BITS
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ld_strobe,
    input logic [FRAME_BITS-1:0] ld_frame0,
    input logic [PAGE_BITS-1:0]  ld_offset,
    input logic [COUNT_BITS-1:0] ld_count,
    input logic                  req_valid,
    input logic [REQ_BITS-1:0]   req_len,
    input logic                  ack_valid,
    input logic [REQ_BITS-1:0]   ack_len,
    input logic [PAGE_BITS-1:0]  ack_offset,
    input logic [ADDR_BITS-1:0]  cur_addr,
    input logic [COUNT_BITS-1:0] remaining,
    input logic                  done,
    input logic                  buf_err
);

    localparam int CW = (REQ_BITS > PAGE_BITS + 1) ? REQ_BITS + 1 : PAGE_BITS + 2;

    logic [CW-1:0] burst_end;
    assign burst_end = CW'(ack_offset) + CW'(ack_len);

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_strobe |=> (remaining == $past(ld_count)) &&
                      (cur_addr[PAGE_BITS-1:0] == $past(ld_offset)) && !buf_err);

    p_first_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_strobe |=> cur_addr[ADDR_BITS-1:PAGE_BITS] == $past(ld_frame0));

    p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> burst_end <= (CW'(1) << PAGE_BITS));

    p_ack_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_len != '0) && (ack_len <= $past(req_len)));

    p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> remaining == $past(remaining) - COUNT_BITS'(ack_len));

    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ld_strobe) |=> !ack_valid);

    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_len == '0) && !ld_strobe) |=> !ack_valid && $stable(remaining));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_err && !ld_strobe) |=> buf_err);

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_err |=> !ack_valid);

    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strobe && req_valid) |=> !ack_valid);

endmodule

bind sg_addr_gen sg_addr_gen_chk #(
    .PAGE_BITS (PAGE_BITS),
    .FRAME_BITS(FRAME_BITS),
    .COUNT_BITS(COUNT_BITS),
    .REQ_BITS  (REQ_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_strobe (ld_strobe),
    .ld_frame0 (ld_frames[FRAME_BITS-1:0]),
    .ld_offset (ld_offset),
    .ld_count  (ld_count),
    .req_valid (req_valid),
    .req_len   (req_len),
    .ack_valid (ack_valid),
    .ack_len   (ack_len),
    .ack_offset(ack_addr[PAGE_BITS-1:0]),
    .cur_addr  (cur_addr),
    .remaining (remaining),
    .done      (done),
    .buf_err   (buf_err)
);

// File: tb/sg_addr_gen_bench.sv
module sg_addr_gen_bench;

    localparam int NP = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_strobe = 1'b0;
    logic [99:0]  ld_frames = '0;
    logic [11:0]  ld_offset = '0;
    logic [14:0]  ld_count = '0;
    logic         req_valid = 1'b0;
    logic [12:0]  req_len = '0;
    logic         ack_valid;
    logic [12:0]  ack_len;
    logic [31:0]  ack_addr;
    logic [31:0]  cur_addr;
    logic [14:0]  remaining;
    logic         done;
    logic         buf_err;

    always #4 clk = ~clk;   // 125 MHz

    sg_addr_gen u_sg_addr_gen (
        .clk(clk), .rst_n(rst_n), .ld_strobe(ld_strobe), .ld_frames(ld_frames),
        .ld_offset(ld_offset), .ld_count(ld_count), .req_valid(req_valid),
        .req_len(req_len), .ack_valid(ack_valid), .ack_len(ack_len),
        .ack_addr(ack_addr), .cur_addr(cur_addr), .remaining(remaining),
        .done(done), .buf_err(buf_err)
    );

    int checks = 0;
    int failures = 0;

    // Reference model built from the requirements.
    logic [19:0] fr [NP];
    int          m_off = 0;
    int          m_idx = 0;
    int          m_rem = 0;
    bit          m_err = 1'b0;

    typedef struct {
        logic [12:0] len;
        logic [31:0] addr;
    } exp_ack_t;

    exp_ack_t sb [$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        logic [31:0] ea;
        ea = {fr[m_idx], 12'(m_off)};
        chk(cur_addr == ea, {tag, " R2 cur_addr"}, cur_addr, ea);
        chk(remaining == 15'(m_rem), {tag, " R5 remaining"}, remaining, m_rem);
        chk(done == (m_rem == 0), {tag, " R5 done"}, done, m_rem == 0);
        chk(buf_err == m_err, {tag, " R7 buf_err"}, buf_err, m_err);
    endtask

    // Monitor: pop one expected acknowledge per granted burst.
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R6 unexpected ack_valid", ack_len, 0);
            end else begin
                exp_ack_t e;
                e = sb.pop_front();
                chk(ack_len == e.len, "R3 ack_len", ack_len, e.len);
                chk(ack_addr == e.addr, "R3 ack_addr", ack_addr, e.addr);
            end
        end
    end

    task automatic set_frames(input int seed);
        for (int i = 0; i < NP; i++) begin
            fr[i] = 20'(seed * 32'h01000 + i * 32'h00111 + 1);
            ld_frames[i*20 +: 20] = fr[i];
        end
    endtask

    task automatic model_load(input int off, input int cnt);
        m_off = off;
        m_idx = 0;
        m_rem = cnt;
        m_err = 1'b0;
    endtask

    task automatic do_load(input int seed, input int off, input int cnt, input bit with_req);
        @(negedge clk);
        set_frames(seed);
        ld_offset = 12'(off);
        ld_count  = 15'(cnt);
        ld_strobe = 1'b1;
        req_valid = with_req;
        req_len   = 13'd64;
        model_load(off, cnt);
        @(posedge clk);
        #1;
        ld_strobe = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(sb.size() == 0, "R1 pending ack after load", sb.size(), 0);
        check_state(with_req ? "R9 load+req" : "R1 load");
    endtask

    task automatic do_req(input int len, input string tag);
        int g;
        @(negedge clk);
        req_valid = 1'b1;
        req_len   = 13'(len);
        if (len != 0 && m_rem != 0 && !m_err) begin
            exp_ack_t e;
            g = len;
            if (g > 4096 - m_off) g = 4096 - m_off;
            if (g > m_rem) g = m_rem;
            e.len  = 13'(g);
            e.addr = {fr[m_idx], 12'(m_off)};
            sb.push_back(e);
            m_rem -= g;
            m_off += g;
            if (m_off == 4096) begin
                m_off = 0;
                if (m_idx == NP - 1) begin
                    if (m_rem != 0) m_err = 1'b1;
                end else begin
                    m_idx++;
                end
            end
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(sb.size() == 0, {tag, " R3 missing ack"}, sb.size(), 0);
        sb.delete();
        check_state(tag);
    endtask

    task automatic run_out(input int len, input string tag);
        for (int n = 0; n < 64 && m_rem != 0 && !m_err; n++) begin
            do_req(len, tag);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NP; i++) fr[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk(remaining == 0 && done && !buf_err && !ack_valid && cur_addr == 0,
            "R10 reset state", {remaining, done, buf_err, ack_valid}, 15'd0 << 3 | 4);
        rst_n = 1'b1;

        // R1/R3/R5: short transfer inside one page, last burst trimmed to remaining
        do_load(1, 12'h010, 100, 1'b0);
        do_req(40, "R3 first burst");
        do_req(100, "R5 trimmed to remaining");
        do_req(16, "R6 request while done");

        // R4: page crossing trims to page room and steps the frame
        do_load(2, 12'hF00, 1000, 1'b0);
        do_req(512, "R4 page room clamp");
        do_req(512, "R4 burst in second page");
        do_req(0, "R6 zero length");
        do_req(4000, "R5 finish");

        // R7: overrun of the last page with bytes left
        do_load(3, 12'h800, 20480, 1'b0);
        run_out(4096, "R7 overrun walk");
        chk(buf_err == 1'b1, "R7 error raised", buf_err, 1);
        do_req(64, "R7 request after error");
        do_req(64, "R7 error sticky");

        // R9: load with simultaneous request; also clears the error (R1)
        do_load(4, 12'h123, 300, 1'b1);
        do_req(300, "R9 after load");

        // R8: full-size transfers at awkward offsets
        do_load(5, 12'h000, 20480, 1'b0);
        run_out(4096, "R8 20KB from 0");
        chk(done && !buf_err, "R8 20KB complete", {done, buf_err}, 2'b10);

        do_load(6, 12'hFFF, 16384, 1'b0);
        run_out(1500, "R8 16KB from FFF");
        chk(done && !buf_err, "R8 16KB from FFF complete", {done, buf_err}, 2'b10);

        do_load(7, 12'h7FF, 16384, 1'b0);
        run_out(8191, "R8 16KB from 7FF");
        chk(done && !buf_err, "R8 16KB from 7FF complete", {done, buf_err}, 2'b10);

        do_load(8, 12'h001, 16384, 1'b0);
        run_out(700, "R8 16KB from 001");
        chk(done && !buf_err, "R8 16KB from 001 complete", {done, buf_err}, 2'b10);

        // R1: zero-count load is done at once
        do_load(9, 12'h040, 0, 1'b0);
        do_req(32, "R6 zero-count request");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule